// File: doc/BRIEF.md
# Orthogonality-Preserving Chip Interleaver

This block permutes one packet of complex chips so that the interleaved multicode sum stays orthogonal to channels that are not interleaved. The packet holds N = WIN_Q x NUM_WIN chips. It is split into N/BLK_L blocks of BLK_L consecutive chips.

The permutation has two stages. The block stage moves whole blocks and keeps the chip order inside each block. It treats each rail of each block as a unit, so the real rail of one block can land in the imaginary rail of another. The window stage then shuffles chips freely, but only inside consecutive windows of WIN_Q chips. One window table is shared by every window. Because of these limits, the overall pattern is not an arbitrary chip shuffle. The same core also undoes the permutation when the mode input is high.

Chips are written into an internal packet buffer in arrival order. When the last chip of the packet has been taken, the block stops accepting input and streams the permuted packet out as one burst. Both tables are loaded through a small write port. The core picks up a new table only between packets.

Top module: `orth_chip_interleaver`

## Requirements
- R1: A packet is N consecutive accepted chips. At the edge that accepts chip N-1, `busy_o` rises. `out_valid_o` rises one edge later and stays high for exactly N cycles. `busy_o` falls at the edge that presents the final output chip.
- R2: Block stage. Rail r (0 = real, 1 = imaginary) of block b is a rail-block with index 2b+r. Block table entry e holds a source rail-block index s. Chip k of the intermediate rail-block e equals chip k of rail s&1 of input block s>>1.
- R3: Window stage. Output chip w*WIN_Q+j equals intermediate chip w*WIN_Q+W[j], where W is the window table.
- R4: In interleave mode (`deint_i` = 0), the output is the block stage followed by the window stage.
- R5: In deinterleave mode (`deint_i` = 1), the exact inverse mapping is applied. An interleaved packet fed back in this mode is returned bit-exactly. The mode is sampled at the edge that accepts the final chip.
- R6: `in_valid_i` is ignored while `busy_o` is high. Chips offered then are neither stored nor counted toward the next packet.
- R7: Table writes use `cfg_sel_i` = 0 for the block table and 1 for the window table, with `cfg_addr_i` as the entry index and `cfg_data_i` as the source index. A packet uses the tables as they stood before its first chip was accepted. A write made while a packet is in progress affects only later packets.
- R8: After reset, `busy_o` and `out_valid_o` are low and both tables hold the identity. A packet therefore passes through unchanged in either mode.
- R9: `out_last_o` is high only with output chip N-1, and `out_valid_o` is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input chip strobe |
| in_re_i | input | DATA_W | Input chip, real rail |
| in_im_i | input | DATA_W | Input chip, imaginary rail |
| busy_o | output | 1 | Packet being read out; input ignored |
| deint_i | input | 1 | 1 = apply inverse mapping |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_sel_i | input | 1 | 0 = block table, 1 = window table |
| cfg_addr_i | input | CFG_W | Table entry index |
| cfg_data_i | input | CFG_W | Source index for the entry |
| out_valid_o | output | 1 | Output chip strobe |
| out_last_o | output | 1 | Final chip of packet |
| out_re_o | output | DATA_W | Output chip, real rail |
| out_im_o | output | DATA_W | Output chip, imaginary rail |

## Verification
A wrong read counter or a wrong address field shows up as a misplaced chip value at the ports. It appears within the burst that follows the packet. Because every test chip carries a unique value on each rail, a crossed rail-select bit is visible as a value from the wrong set. A stuck FSM or a wrong fill count shows up within one packet length. It appears as a burst of the wrong length, a misplaced `out_last_o`, or `busy_o` rising off the N-th chip. If the inverse table is corrupted, the round trip returns a different packet on its very next burst.

// File: rtl/orth_ilv_pkg.sv
package orth_ilv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_READ = 2'd2
  } ilv_state_e;

  localparam logic TBL_BLOCK  = 1'b0;
  localparam logic TBL_WINDOW = 1'b1;
  localparam int   RAIL_RE    = 0;
  localparam int   RAIL_IM    = 1;
endpackage

// File: rtl/ilv_perm_tables.sv
module ilv_perm_tables
  import orth_ilv_pkg::*;
#(
  parameter int NRB   = 16,
  parameter int RB_W  = 4,
  parameter int WIN_Q = 16,
  parameter int Q_B   = 4,
  parameter int CFG_W = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic                        sel_i,
  input  logic [CFG_W-1:0]            addr_i,
  input  logic [CFG_W-1:0]            data_i,
  input  logic                        refresh_i,
  output logic [NRB-1:0][RB_W-1:0]    blk_fwd_o,
  output logic [NRB-1:0][RB_W-1:0]    blk_inv_o,
  output logic [WIN_Q-1:0][Q_B-1:0]   win_fwd_o,
  output logic [WIN_Q-1:0][Q_B-1:0]   win_inv_o
);
  // staging copy takes writes at any time; working copy follows it only between packets
  logic [NRB-1:0][RB_W-1:0]  stg_bf, stg_bi;
  logic [WIN_Q-1:0][Q_B-1:0] stg_wf, stg_wi;

  logic [RB_W-1:0] b_addr, b_data;
  logic [Q_B-1:0]  w_addr, w_data;

  assign b_addr = addr_i[RB_W-1:0];
  assign b_data = data_i[RB_W-1:0];
  assign w_addr = addr_i[Q_B-1:0];
  assign w_data = data_i[Q_B-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NRB; i++) begin
        stg_bf[i] <= RB_W'(i);
        stg_bi[i] <= RB_W'(i);
      end
      for (int i = 0; i < WIN_Q; i++) begin
        stg_wf[i] <= Q_B'(i);
        stg_wi[i] <= Q_B'(i);
      end
    end else if (we_i) begin
      if (sel_i == TBL_BLOCK) begin
        stg_bf[b_addr] <= b_data;
        stg_bi[b_data] <= b_addr;
      end else begin
        stg_wf[w_addr] <= w_data;
        stg_wi[w_data] <= w_addr;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NRB; i++) begin
        blk_fwd_o[i] <= RB_W'(i);
        blk_inv_o[i] <= RB_W'(i);
      end
      for (int i = 0; i < WIN_Q; i++) begin
        win_fwd_o[i] <= Q_B'(i);
        win_inv_o[i] <= Q_B'(i);
      end
    end else if (refresh_i) begin
      blk_fwd_o <= stg_bf;
      blk_inv_o <= stg_bi;
      win_fwd_o <= stg_wf;
      win_inv_o <= stg_wi;
    end
  end
endmodule

// File: rtl/ilv_pkt_buf.sv
module ilv_pkt_buf #(
  parameter int DEPTH = 32,
  parameter int AW    = 5,
  parameter int DW    = 16
) (
  input  logic                  clk_i,
  input  logic                  we_i,
  input  logic [AW-1:0]         wr_addr_i,
  input  logic [DW-1:0]         wr_data_i,
  input  logic [1:0][AW-1:0]    rd_addr_i,
  output logic [1:0][DW-1:0]    rd_data_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[wr_addr_i] <= wr_data_i;
  end

  // one read port per output rail: the two rails may come from different chips
  for (genvar p = 0; p < 2; p++) begin : g_rd
    assign rd_data_o[p] = mem[rd_addr_i[p]];
  end
endmodule

// File: rtl/ilv_addr_gen.sv
module ilv_addr_gen #(
  parameter int N_W   = 5,
  parameter int L_B   = 2,
  parameter int Q_B   = 4,
  parameter int RB_W  = 4,
  parameter int NRB   = 16,
  parameter int WIN_Q = 16
) (
  input  logic [N_W-1:0]              idx_i,
  input  logic                        inv_i,
  input  logic [NRB-1:0][RB_W-1:0]    blk_fwd_i,
  input  logic [NRB-1:0][RB_W-1:0]    blk_inv_i,
  input  logic [WIN_Q-1:0][Q_B-1:0]   win_fwd_i,
  input  logic [WIN_Q-1:0][Q_B-1:0]   win_inv_i,
  output logic [1:0][N_W-1:0]         addr_o,
  output logic [1:0]                  rail_o
);
  localparam logic [N_W-1:0] L_MASK = N_W'((1 << L_B) - 1);
  localparam logic [N_W-1:0] Q_MASK = N_W'((1 << Q_B) - 1);

  // forward: undo the window stage first, then locate the block
  logic [N_W-1:0] t_fwd, bi_fwd, k_fwd;
  // inverse: locate the block first, then the window position
  logic [N_W-1:0] bi_inv, k_inv;

  always_comb begin
    t_fwd  = (idx_i & ~Q_MASK) | N_W'(win_fwd_i[idx_i[Q_B-1:0]]);
    bi_fwd = t_fwd >> L_B;
    k_fwd  = t_fwd & L_MASK;
    bi_inv = idx_i >> L_B;
    k_inv  = idx_i & L_MASK;
  end

  for (genvar r = 0; r < 2; r++) begin : g_rail
    localparam logic [N_W-1:0] RSEL = N_W'(r);
    logic [RB_W-1:0] rb_fwd, rb_inv, s_fwd, p_inv;
    logic [N_W-1:0]  s_ext, p_ext, a_fwd, t_inv, a_inv;

    always_comb begin
      rb_fwd = RB_W'((bi_fwd << 1) | RSEL);
      s_fwd  = blk_fwd_i[rb_fwd];
      s_ext  = N_W'(s_fwd);
      a_fwd  = ((s_ext >> 1) << L_B) | k_fwd;

      rb_inv = RB_W'((bi_inv << 1) | RSEL);
      p_inv  = blk_inv_i[rb_inv];
      p_ext  = N_W'(p_inv);
      t_inv  = ((p_ext >> 1) << L_B) | k_inv;
      a_inv  = (t_inv & ~Q_MASK) | N_W'(win_inv_i[t_inv[Q_B-1:0]]);

      addr_o[r] = inv_i ? a_inv : a_fwd;
      rail_o[r] = inv_i ? p_inv[0] : s_fwd[0];
    end
  end
endmodule

// File: rtl/orth_chip_interleaver.sv
module orth_chip_interleaver
  import orth_ilv_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int BLK_L   = 4,
  parameter int WIN_Q   = 16,
  parameter int NUM_WIN = 2,
  localparam int N_CHIP = WIN_Q * NUM_WIN,
  localparam int N_W    = $clog2(N_CHIP),
  localparam int L_B    = $clog2(BLK_L),
  localparam int Q_B    = $clog2(WIN_Q),
  localparam int NRB    = 2 * N_CHIP / BLK_L,
  localparam int RB_W   = $clog2(NRB),
  localparam int CFG_W  = (RB_W > Q_B) ? RB_W : Q_B
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_re_i,
  input  logic [DATA_W-1:0] in_im_i,
  output logic              busy_o,
  input  logic              deint_i,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [CFG_W-1:0]  cfg_addr_i,
  input  logic [CFG_W-1:0]  cfg_data_i,
  output logic              out_valid_o,
  output logic              out_last_o,
  output logic [DATA_W-1:0] out_re_o,
  output logic [DATA_W-1:0] out_im_o
);
  localparam logic [N_W-1:0] LAST_IDX = N_W'(N_CHIP - 1);
  localparam int             DW2      = 2 * DATA_W;

  ilv_state_e state_q;
  logic [N_W-1:0] wr_cnt_q, rd_cnt_q;
  logic           mode_q;
  logic           accept, refresh;

  logic [NRB-1:0][RB_W-1:0]  blk_fwd, blk_inv;
  logic [WIN_Q-1:0][Q_B-1:0] win_fwd, win_inv;
  logic [1:0][N_W-1:0]       rd_addr;
  logic [1:0]                rd_rail;
  logic [1:0][DW2-1:0]       rd_word;
  logic [1:0][DATA_W-1:0]    rail_val;

  assign accept  = in_valid_i && (state_q != ST_READ);
  assign refresh = (state_q == ST_IDLE);
  assign busy_o  = (state_q == ST_READ);

  ilv_perm_tables #(
    .NRB(NRB), .RB_W(RB_W), .WIN_Q(WIN_Q), .Q_B(Q_B), .CFG_W(CFG_W)
  ) u_tables (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .sel_i     (cfg_sel_i),
    .addr_i    (cfg_addr_i),
    .data_i    (cfg_data_i),
    .refresh_i (refresh),
    .blk_fwd_o (blk_fwd),
    .blk_inv_o (blk_inv),
    .win_fwd_o (win_fwd),
    .win_inv_o (win_inv)
  );

  ilv_pkt_buf #(.DEPTH(N_CHIP), .AW(N_W), .DW(DW2)) u_buf (
    .clk_i     (clk_i),
    .we_i      (accept),
    .wr_addr_i (wr_cnt_q),
    .wr_data_i ({in_re_i, in_im_i}),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_word)
  );

  ilv_addr_gen #(
    .N_W(N_W), .L_B(L_B), .Q_B(Q_B), .RB_W(RB_W), .NRB(NRB), .WIN_Q(WIN_Q)
  ) u_addr (
    .idx_i     (rd_cnt_q),
    .inv_i     (mode_q),
    .blk_fwd_i (blk_fwd),
    .blk_inv_i (blk_inv),
    .win_fwd_i (win_fwd),
    .win_inv_i (win_inv),
    .addr_o    (rd_addr),
    .rail_o    (rd_rail)
  );

  // buffer word is {re, im}; rail bit 1 picks the imaginary half
  for (genvar r = 0; r < 2; r++) begin : g_sel
    assign rail_val[r] = rd_rail[r] ? rd_word[r][DATA_W-1:0] : rd_word[r][DW2-1:DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      wr_cnt_q <= '0;
      rd_cnt_q <= '0;
      mode_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_FILL: begin
          if (accept) begin
            if (wr_cnt_q == LAST_IDX) begin
              state_q  <= ST_READ;
              wr_cnt_q <= '0;
              rd_cnt_q <= '0;
              mode_q   <= deint_i;
            end else begin
              state_q  <= ST_FILL;
              wr_cnt_q <= wr_cnt_q + 1'b1;
            end
          end
        end
        ST_READ: begin
          rd_cnt_q <= rd_cnt_q + 1'b1;
          if (rd_cnt_q == LAST_IDX) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_last_o  <= 1'b0;
      out_re_o    <= '0;
      out_im_o    <= '0;
    end else begin
      out_valid_o <= busy_o;
      out_last_o  <= busy_o && (rd_cnt_q == LAST_IDX);
      if (busy_o) begin
        out_re_o <= rail_val[RAIL_RE];
        out_im_o <= rail_val[RAIL_IM];
      end
    end
  end
endmodule

// File: rtl/orth_chip_interleaver_chk.sv
module orth_chip_interleaver_chk #(
  parameter int N_CHIP = 32
) (
  input logic clk_i,
  input logic rst_ni,
  input logic in_valid_i,
  input logic busy_o,
  input logic out_valid_o,
  input logic out_last_o
);
  localparam int N_W = $clog2(N_CHIP);
  localparam logic [N_W-1:0] LAST_IDX = N_W'(N_CHIP - 1);

  logic [N_W-1:0] acc_cnt, out_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_cnt <= '0;
      out_cnt <= '0;
    end else begin
      if (in_valid_i && !busy_o) acc_cnt <= (acc_cnt == LAST_IDX) ? '0 : acc_cnt + 1'b1;
      if (out_valid_o) out_cnt <= out_last_o ? '0 : out_cnt + 1'b1;
    end
  end

  AST_FULL_THEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !busy_o && acc_cnt == LAST_IDX) |=> busy_o); // R1
  AST_BUSY_ONLY_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !(in_valid_i && acc_cnt == LAST_IDX)) |=> !busy_o); // R6
  AST_BURST_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> out_valid_o); // R1
  AST_BURST_CONT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_last_o) |=> out_valid_o); // R1
  AST_LAST_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> !busy_o); // R1
  AST_LAST_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> (out_valid_o && out_cnt == LAST_IDX)); // R9
  AST_LAST_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |=> !out_valid_o); // R9
endmodule

bind orth_chip_interleaver orth_chip_interleaver_chk #(.N_CHIP(WIN_Q * NUM_WIN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .busy_o      (busy_o),
  .out_valid_o (out_valid_o),
  .out_last_o  (out_last_o)
);

// File: tb/orth_chip_interleaver_test.sv
module orth_chip_interleaver_test;
  localparam int DW = 8, L = 4, Q = 16, NW = 2;
  localparam int N = Q * NW;
  localparam int M = N / L;
  localparam int NRB = 2 * M;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic in_valid = 1'b0, deint = 1'b0;
  logic [DW-1:0] in_re = '0, in_im = '0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [3:0] cfg_addr = '0, cfg_data = '0;
  logic busy, out_valid, out_last;
  logic [DW-1:0] out_re, out_im;

  int n_chk = 0, n_fail = 0;

  logic [DW-1:0] x_re [N], x_im [N];
  logic [DW-1:0] c_re [N], c_im [N];
  logic [DW-1:0] e_re [N], e_im [N];
  int bp [NRB];
  int wp [Q];

  always #4 clk = ~clk;

  orth_chip_interleaver #(.DATA_W(DW), .BLK_L(L), .WIN_Q(Q), .NUM_WIN(NW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_re_i(in_re), .in_im_i(in_im),
    .busy_o(busy), .deint_i(deint), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data), .out_valid_o(out_valid),
    .out_last_o(out_last), .out_re_o(out_re), .out_im_o(out_im)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
  end

  task automatic cfg_write(input logic sel, input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_addr = 4'(a); cfg_data = 4'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_all();
    for (int i = 0; i < NRB; i++) cfg_write(1'b0, i, bp[i]);
    for (int i = 0; i < Q; i++) cfg_write(1'b1, i, wp[i]);
  endtask

  task automatic fill_pattern(input int seed);
    for (int i = 0; i < N; i++) begin
      x_re[i] = DW'(seed + i);
      x_im[i] = DW'(seed + 8'h80 + i);
    end
  endtask

  // spec of the forward mapping (R2, R3, R4)
  task automatic compute_ilv();
    for (int n = 0; n < N; n++) begin
      int t, b, k, s, src;
      t = (n / Q) * Q + wp[n % Q];
      b = t / L; k = t % L;
      s = bp[2 * b];
      src = (s / 2) * L + k;
      e_re[n] = (s % 2) ? x_im[src] : x_re[src];
      s = bp[2 * b + 1];
      src = (s / 2) * L + k;
      e_im[n] = (s % 2) ? x_im[src] : x_re[src];
    end
  endtask

  // drives x_*, captures into c_*; R1/R9 protocol checks, optional R6 junk and R7 mid-packet write
  task automatic run_packet(input logic mode, input bit junk, input bit mid_cfg,
                            input int mid_addr, input int mid_data);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_re = x_re[i]; in_im = x_im[i];
      deint = mode;
      cfg_we = (mid_cfg && i == 10);
      cfg_sel = 1'b1; cfg_addr = 4'(mid_addr); cfg_data = 4'(mid_data);
    end
    @(negedge clk);
    cfg_we = 1'b0;
    deint = ~mode;
    if (junk) begin in_valid = 1'b1; in_re = 8'hFF; in_im = 8'hFF; end
    else in_valid = 1'b0;
    check(busy == 1'b1 && out_valid == 1'b0, "R1 busy after last chip", {busy, out_valid}, 2);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      if (i == N - 1) in_valid = 1'b0;
      c_re[i] = out_re; c_im[i] = out_im;
      if (!out_valid) check(0, "R1 burst valid", i, 1);
      if (out_last != (i == N - 1)) check(0, "R9 last position", i, N - 1);
      if (busy != (i != N - 1)) check(0, "R1 busy during burst", i, busy);
    end
    check(1, "R1 burst", 0, 0);
    @(negedge clk);
    check(out_valid == 1'b0 && busy == 1'b0, "R9 gap after last", {busy, out_valid}, 0);
  endtask

  task automatic compare(input string req);
    for (int n = 0; n < N; n++)
      check(c_re[n] == e_re[n] && c_im[n] == e_im[n], req,
            {c_re[n], c_im[n]}, {e_re[n], e_im[n]});
  endtask

  task automatic set_identity();
    for (int i = 0; i < NRB; i++) bp[i] = i;
    for (int i = 0; i < Q; i++) wp[i] = i;
  endtask

  task automatic t_reset();
    check(busy == 1'b0, "R8 reset busy", busy, 0);
    check(out_valid == 1'b0 && out_last == 1'b0, "R8 reset valid", out_valid, 0);
  endtask

  task automatic t_identity();
    set_identity();
    fill_pattern(8'h10);
    for (int i = 0; i < N; i++) begin e_re[i] = x_re[i]; e_im[i] = x_im[i]; end
    run_packet(1'b0, 0, 0, 0, 0);
    compare("R8 identity interleave");
    run_packet(1'b1, 0, 0, 0, 0);
    compare("R8 identity deinterleave");
  endtask

  task automatic t_block();
    set_identity();
    for (int b = 0; b < M; b++) begin
      bp[2 * b]     = 2 * (M - 1 - b) + 1;
      bp[2 * b + 1] = 2 * ((b + 3) % M);
    end
    load_all();
    fill_pattern(8'h00);
    compute_ilv();
    run_packet(1'b0, 0, 0, 0, 0);
    compare("R2 block stage with rail exchange");
  endtask

  task automatic t_window();
    set_identity();
    for (int j = 0; j < Q; j++) wp[j] = (j * 5 + 3) % Q;
    load_all();
    fill_pattern(8'h20);
    compute_ilv();
    run_packet(1'b0, 0, 0, 0, 0);
    compare("R3 window stage");
  endtask

  task automatic t_combined_roundtrip();
    logic [DW-1:0] o_re [N], o_im [N];
    for (int b = 0; b < M; b++) begin
      bp[2 * b]     = 2 * ((b * 3 + 1) % M) + 1;
      bp[2 * b + 1] = 2 * ((b + 5) % M);
    end
    for (int j = 0; j < Q; j++) wp[j] = (j * 7 + 2) % Q;
    load_all();
    fill_pattern(8'h33);
    compute_ilv();
    run_packet(1'b0, 0, 0, 0, 0);
    compare("R4 block then window");
    for (int i = 0; i < N; i++) begin
      o_re[i] = x_re[i]; o_im[i] = x_im[i];
      x_re[i] = c_re[i]; x_im[i] = c_im[i];
    end
    for (int i = 0; i < N; i++) begin e_re[i] = o_re[i]; e_im[i] = o_im[i]; end
    run_packet(1'b1, 0, 0, 0, 0);
    compare("R5 round trip restores packet");
  endtask

  task automatic t_busy_ignore();
    fill_pattern(8'h41);
    compute_ilv();
    run_packet(1'b0, 1, 0, 0, 0);
    compare("R6 packet with junk offered");
    fill_pattern(8'h05);
    compute_ilv();
    run_packet(1'b0, 0, 0, 0, 0);
    compare("R6 next packet aligned after junk");
  endtask

  task automatic t_cfg_defer();
    fill_pattern(8'h61);
    compute_ilv();
    run_packet(1'b0, 0, 1, 0, wp[1]);
    compare("R7 mid-packet write deferred");
    wp[0] = wp[1];
    fill_pattern(8'h12);
    compute_ilv();
    run_packet(1'b0, 0, 0, 0, 0);
    compare("R7 write applied to next packet");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_identity();
    t_block();
    t_window();
    t_combined_roundtrip();
    t_busy_ignore();
    t_cfg_defer();
    repeat (4) @(negedge clk);
    summary();
  end
endmodule